// File: doc/BRIEF.md
# I2C Master SCL Bit Timing Generator

This block produces the SCL clock waveform for an I2C master and, for each bit, one strobe telling the data path when to sample SDA and one telling it when to change SDA. It runs from a fixed 24 MHz block clock, and every duration it produces is a whole number of those cycles. The data path around it handles bytes, acknowledges and the SDA pin. It asks this block to open a transfer, to advance to the next bit or to close the transfer. The block answers with the SCL level, the two strobes, a bus-free busy flag and a phase code.

The timing comes from three 32-bit configuration words. `cfg_word0` holds the SCL high count in bits [31:16] and the receive sample offset in bits [15:0]. `cfg_word1` holds the SCL low count in bits [31:16] and the transmit change offset in bits [15:0]. `cfg_word2` holds the bus-free count in bits [31:16] and the START hold (lead-in) count in bits [15:0]. The hardware adds a fixed overhead to each programmed phase: 7 cycles to every high phase and 2 cycles to every low phase. Only the low 10 bits of the high and low counts are used. All three words are copied into a shadow register at the moment a START is accepted. Reset loads the shadow copy of the third word with 0x00300030 and treats reset as if a STOP had just finished.

The state machine has seven states:
- IDLE: SCL high, waiting for a start.
- LEADIN: START hold.
- LOW: SCL low phase.
- HIGH: SCL high phase.
- PARK: SCL held low between bits.
- STOPHI: SCL high before the STOP.
- BUSFREE: bus-free wait.

It has these transitions:
- IDLE→LEADIN on an accepted start.
- LEADIN→LOW when the lead-in ends.
- LOW→HIGH when the low phase ends.
- HIGH→LOW when the high phase ends with the advance request set.
- HIGH→PARK when the high phase ends without it.
- PARK→STOPHI on a stop request.
- PARK→LOW on an advance request.
- STOPHI→BUSFREE when the stop high time ends.
- BUSFREE→IDLE when the bus-free count ends.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the phase is BUSFREE with SCL high and `busy_o` high for exactly 48 cycles, the count in the reset value 0x00300030 of the third word's shadow copy. The phase is then IDLE.
- R2: When `start_req` is high in IDLE, the words are captured and LEADIN follows for max(cfg_word2[15:0], 1) cycles with SCL high. LOW comes next.
- R3: Every LOW phase lasts cfg_word1[25:16] + 2 cycles. SCL is low in LOW and PARK and high in every other phase.
- R4: Every HIGH phase lasts cfg_word0[25:16] + 7 cycles.
- R5: Bits [31:26] of the high count field and of the low count field have no effect on any duration.
- R6: `sample_stb` fires for one cycle in a HIGH phase, in the cycle whose index from the start of the phase (first cycle = 0) equals cfg_word0[15:0]. It does not fire if that offset is not below the phase length, and never fires in any other phase.
- R7: `drive_stb` behaves the same way in each LOW phase, at index cfg_word1[15:0].
- R8: When `bit_adv` is high in the last HIGH cycle, LOW follows immediately. Otherwise PARK follows. In PARK, `stop_req` leads to STOPHI and takes priority over `bit_adv`, which leads to LOW. `stop_req` and `bit_adv` are ignored in the other phases.
- R9: STOPHI lasts cfg_word0[25:16] + 7 cycles with SCL high and no sample strobe. BUSFREE follows for max(cfg_word2[31:16], 1) cycles with `busy_o` high, then IDLE.
- R10: `start_req` is ignored outside IDLE. A start held high through BUSFREE is accepted after exactly one IDLE cycle.
- R11: Changes to the configuration words after a START is accepted have no effect until the next accepted START.
- R12: `phase_o` encodes the phases as IDLE=0, LEADIN=1, LOW=2, HIGH=3, PARK=4, STOPHI=5, BUSFREE=6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word0 | input | 32 | High count [31:16], sample offset [15:0] |
| cfg_word1 | input | 32 | Low count [31:16], change offset [15:0] |
| cfg_word2 | input | 32 | Bus-free count [31:16], lead-in count [15:0] |
| start_req | input | 1 | Open a transfer (taken in IDLE) |
| stop_req | input | 1 | Close the transfer (taken in PARK) |
| bit_adv | input | 1 | Advance to the next bit |
| scl_o | output | 1 | SCL level |
| sample_stb | output | 1 | One-cycle sample-SDA strobe |
| drive_stb | output | 1 | One-cycle change-SDA strobe |
| busy_o | output | 1 | Bus-free wait in progress |
| phase_o | output | 3 | Current phase code |

## Verification
The hardest situation to reach is a start request that is already waiting while the bus-free count runs. The block must hold that request off and then accept it after exactly one IDLE cycle. The bench reaches it right after reset and again after some transfers, where the driver returns as soon as BUSFREE appears and raises the next start at once. A sweep over small high and low counts, lead-in and bus-free values, and strobe offsets at zero, at the last cycle and past the end covers every phase length and strobe position. The sweep mixes back-to-back bits, parked gaps and stop requests raised together with an advance request.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_LEADIN  = 3'd1,
        PH_LOW     = 3'd2,
        PH_HIGH    = 3'd3,
        PH_PARK    = 3'd4,
        PH_STOPHI  = 3'd5,
        PH_BUSFREE = 3'd6
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hi_cnt;
        logic [FIELD_W-1:0] rx_off;
        logic [FIELD_W-1:0] lo_cnt;
        logic [FIELD_W-1:0] tx_off;
        logic [FIELD_W-1:0] free_cnt;
        logic [FIELD_W-1:0] lead_cnt;
    } timing_s;
endpackage

// File: rtl/scl_timing_shadow.sv
module scl_timing_shadow
    import scl_timing_pkg::*;
#(
    parameter int               SIG_W  = 10,
    parameter logic [WORD_W-1:0] W2_RST = 32'h0030_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output timing_s           cfg
);
    localparam int NWORDS = 3;
    localparam logic [FIELD_W-1:0] SIG_MASK = FIELD_W'((1 << SIG_W) - 1);

    logic [WORD_W-1:0] in_w [NWORDS];
    assign in_w[0] = word0;
    assign in_w[1] = word1;
    assign in_w[2] = word2;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] RST_V = (g == 2) ? W2_RST : '0;
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= RST_V;
            else if (capture) q <= in_w[g];
        end
    end

    always_comb begin
        cfg.hi_cnt   = g_word[0].q[WORD_W-1 -: FIELD_W] & SIG_MASK;
        cfg.rx_off   = g_word[0].q[FIELD_W-1:0];
        cfg.lo_cnt   = g_word[1].q[WORD_W-1 -: FIELD_W] & SIG_MASK;
        cfg.tx_off   = g_word[1].q[FIELD_W-1:0];
        cfg.free_cnt = g_word[2].q[WORD_W-1 -: FIELD_W];
        cfg.lead_cnt = g_word[2].q[FIELD_W-1:0];
    end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [CNT_W:0] dur,
    output logic [CNT_W-1:0] cnt,
    output logic           last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign last = ({1'b0, cnt} == dur - (CNT_W+1)'(1));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int HI_EXTRA = 7,
    parameter int LO_EXTRA = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               bit_adv,
    input  timing_s            cfg,
    input  logic [FIELD_W-1:0] cnt,
    input  logic               last,
    output phase_e             state,
    output logic               cnt_clr,
    output logic [FIELD_W:0]   dur,
    output logic               capture,
    output logic               scl,
    output logic               sample_stb,
    output logic               drive_stb,
    output logic               busy
);
    localparam int DUR_W = FIELD_W + 1;

    phase_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_BUSFREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:    if (start_req) state_nx = PH_LEADIN;
            PH_LEADIN:  if (last)      state_nx = PH_LOW;
            PH_LOW:     if (last)      state_nx = PH_HIGH;
            PH_HIGH:    if (last)      state_nx = bit_adv ? PH_LOW : PH_PARK;
            PH_PARK: begin
                if (stop_req)     state_nx = PH_STOPHI;
                else if (bit_adv) state_nx = PH_LOW;
            end
            PH_STOPHI:  if (last)      state_nx = PH_BUSFREE;
            PH_BUSFREE: if (last)      state_nx = PH_IDLE;
            default:                   state_nx = PH_BUSFREE;
        endcase
    end

    assign cnt_clr = (state_nx != state);
    assign capture = (state == PH_IDLE) && start_req;

    always_comb begin
        dur = DUR_W'(1);
        unique case (state)
            PH_LEADIN:  dur = (cfg.lead_cnt == '0) ? DUR_W'(1) : DUR_W'(cfg.lead_cnt);
            PH_LOW:     dur = DUR_W'(cfg.lo_cnt) + DUR_W'(LO_EXTRA);
            PH_HIGH,
            PH_STOPHI:  dur = DUR_W'(cfg.hi_cnt) + DUR_W'(HI_EXTRA);
            PH_BUSFREE: dur = (cfg.free_cnt == '0) ? DUR_W'(1) : DUR_W'(cfg.free_cnt);
            default:    dur = DUR_W'(1);
        endcase
    end

    always_comb begin
        scl        = 1'b1;
        sample_stb = 1'b0;
        drive_stb  = 1'b0;
        busy       = 1'b0;
        unique case (state)
            PH_LOW: begin
                scl       = 1'b0;
                drive_stb = (cnt == cfg.tx_off);
            end
            PH_PARK:    scl = 1'b0;
            PH_HIGH:    sample_stb = (cnt == cfg.rx_off);
            PH_BUSFREE: busy = 1'b1;
            default: ;
        endcase
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && start_req) |=> (state == PH_LEADIN));

    // R8
    stop_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PARK && stop_req) |=> (state == PH_STOPHI));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_BUSFREE && !last) |=> (state == PH_BUSFREE));

    // R4
    high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |-> ({1'b0, cnt} < dur));

    // R6
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int               SIG_W    = 10,
    parameter int               HI_EXTRA = 7,
    parameter int               LO_EXTRA = 2,
    parameter logic [WORD_W-1:0] W2_RST  = 32'h0030_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word0,
    input  logic [WORD_W-1:0] cfg_word1,
    input  logic [WORD_W-1:0] cfg_word2,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              bit_adv,
    output logic              scl_o,
    output logic              sample_stb,
    output logic              drive_stb,
    output logic              busy_o,
    output logic [2:0]        phase_o
);
    timing_s            cfg;
    phase_e             phase;
    logic               capture;
    logic               cnt_clr;
    logic               last;
    logic [FIELD_W:0]   dur;
    logic [FIELD_W-1:0] cnt;

    scl_timing_shadow #(
        .SIG_W  (SIG_W),
        .W2_RST (W2_RST)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .word0   (cfg_word0),
        .word1   (cfg_word1),
        .word2   (cfg_word2),
        .cfg     (cfg)
    );

    scl_phase_counter #(
        .CNT_W (FIELD_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .dur   (dur),
        .cnt   (cnt),
        .last  (last)
    );

    scl_phase_fsm #(
        .HI_EXTRA (HI_EXTRA),
        .LO_EXTRA (LO_EXTRA)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .bit_adv    (bit_adv),
        .cfg        (cfg),
        .cnt        (cnt),
        .last       (last),
        .state      (phase),
        .cnt_clr    (cnt_clr),
        .dur        (dur),
        .capture    (capture),
        .scl        (scl_o),
        .sample_stb (sample_stb),
        .drive_stb  (drive_stb),
        .busy       (busy_o)
    );

    assign phase_o = 3'(phase);

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(cfg));
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] w0 = '0, w1 = '0, w2 = '0;
    logic        start_req = 1'b0, stop_req = 1'b0, bit_adv = 1'b0;
    logic        scl_o, sample_stb, drive_stb, busy_o;
    logic [2:0]  phase_o;

    always #2 clk = ~clk;

    scl_timing_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_word0(w0), .cfg_word1(w1), .cfg_word2(w2),
        .start_req(start_req), .stop_req(stop_req), .bit_adv(bit_adv),
        .scl_o(scl_o), .sample_stb(sample_stb), .drive_stb(drive_stb),
        .busy_o(busy_o), .phase_o(phase_o)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // active timing model (captured at start acceptance) and pending values
    int a_hi = 0, a_lo = 0, a_ro = 0, a_xo = 0, a_li = 1, a_bf = 48;
    int p_hi = 0, p_lo = 0, p_ro = 0, p_xo = 0, p_li = 1, p_bf = 1;
    bit expect_quick = 1'b0;
    int prev_ph = 7, run = 0, s_cnt = 0, d_cnt = 0, hi_entries = 0;
    int last_hi_len = 0, last_lo_len = 0;

    function automatic int want_len(input int ph);
        case (ph)
            1:       return a_li;
            2:       return a_lo + 2;
            3, 5:    return a_hi + 7;
            6:       return a_bf;
            default: return -1;
        endcase
    endfunction

    function automatic string req_of(input int ph);
        case (ph)
            1:       return "R2";
            2:       return "R3";
            3:       return "R4";
            default: return "R9";
        endcase
    endfunction

    function automatic bit legal_next(input int from, input int to);
        case (from)
            0: return to == 1;
            1: return to == 2;
            2: return to == 3;
            3: return to == 2 || to == 4;
            4: return to == 2 || to == 5;
            5: return to == 6;
            6: return to == 0;
            default: return 1'b1;
        endcase
    endfunction

    always @(negedge clk) begin
        int ph;
        if (rst_n) begin
            ph = int'(phase_o);
            if (ph != prev_ph) begin
                if (prev_ph == 7) begin
                    chk(ph == 6 && busy_o && scl_o, "R1", "reset state", ph, 6);
                    chk(ph == 6, "R12", "busfree code", ph, 6);
                end else begin
                    chk(legal_next(prev_ph, ph), "R8", "phase order", ph, prev_ph);
                    if (want_len(prev_ph) > 0)
                        chk(run == want_len(prev_ph), req_of(prev_ph), "phase length",
                            run, want_len(prev_ph));
                    if (prev_ph == 3) begin
                        chk(s_cnt == ((a_ro < a_hi + 7) ? 1 : 0), "R6", "samples per high",
                            s_cnt, (a_ro < a_hi + 7) ? 1 : 0);
                        last_hi_len = run;
                    end
                    if (prev_ph == 2) begin
                        chk(d_cnt == ((a_xo < a_lo + 2) ? 1 : 0), "R7", "drives per low",
                            d_cnt, (a_xo < a_lo + 2) ? 1 : 0);
                        last_lo_len = run;
                    end
                    if (prev_ph == 5)
                        chk(s_cnt == 0, "R9", "no sample in stop high", s_cnt, 0);
                end
                if (ph == 1) begin
                    chk(prev_ph == 0, "R10", "leadin only from idle", prev_ph, 0);
                    if (expect_quick) begin
                        chk(run == 1, "R10", "idle cycles before held start", run, 1);
                        expect_quick = 1'b0;
                    end
                    a_hi = p_hi; a_lo = p_lo; a_ro = p_ro; a_xo = p_xo;
                    a_li = p_li; a_bf = p_bf;
                end
                if (ph == 3) hi_entries++;
                run = 1; s_cnt = 0; d_cnt = 0;
            end else begin
                run++;
            end
            if (sample_stb) begin
                chk(ph == 3 && run - 1 == a_ro, "R6", "sample position", run - 1, a_ro);
                s_cnt++;
            end
            if (drive_stb) begin
                chk(ph == 2 && run - 1 == a_xo, "R7", "drive position", run - 1, a_xo);
                d_cnt++;
            end
            chk(scl_o == !(ph == 2 || ph == 4), "R3", "scl level", int'(scl_o),
                (ph == 2 || ph == 4) ? 0 : 1);
            chk(busy_o == (ph == 6), "R9", "busy flag", int'(busy_o), (ph == 6) ? 1 : 0);
            prev_ph = ph;
        end
    end

    task automatic run_xfer(input logic [15:0] hi, input logic [15:0] lo,
                            input logic [15:0] ro, input logic [15:0] xo,
                            input logic [15:0] li, input logic [15:0] bf,
                            input int nbits, input bit gap, input bit both,
                            input bit mutate, input bit early);
        int base;
        @(negedge clk);
        w0 = {hi, ro}; w1 = {lo, xo}; w2 = {bf, li};
        p_hi = int'(hi & 16'h03FF); p_lo = int'(lo & 16'h03FF);
        p_ro = int'(ro); p_xo = int'(xo);
        p_li = (li == 16'd0) ? 1 : int'(li);
        p_bf = (bf == 16'd0) ? 1 : int'(bf);
        expect_quick = (phase_o == 3'd6) || (phase_o == 3'd5);
        start_req = 1'b1;
        while (phase_o != 3'd1) @(negedge clk);
        start_req = mutate;
        if (mutate) begin
            w0 = ~w0; w1 = ~w1; w2 = ~w2;
        end
        base = hi_entries;
        bit_adv = (nbits > 1);
        if (gap && nbits > 1) begin
            while (hi_entries - base < 1) @(negedge clk);
            bit_adv = 1'b0;
            while (phase_o != 3'd4) @(negedge clk);
            repeat (3) @(negedge clk);
            bit_adv = 1'b1;
        end
        while (hi_entries - base < nbits) @(negedge clk);
        bit_adv = 1'b0;
        start_req = 1'b0;
        while (phase_o != 3'd4) @(negedge clk);
        repeat (2) @(negedge clk);
        stop_req = 1'b1;
        bit_adv = both;
        @(negedge clk);
        chk(phase_o == 3'd5, "R8", "stop taken from park", int'(phase_o), 5);
        stop_req = 1'b0;
        bit_adv = 1'b0;
        if (early) while (phase_o != 3'd6) @(negedge clk);
        else       while (phase_o != 3'd0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hv, lv, liv, bfv, idx, hd, ldur, rov, xov;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 / R10: start requested while the reset bus-free wait runs
        run_xfer(16'd2, 16'd1, 16'd0, 16'd0, 16'd1, 16'd1, 2, 1'b0, 1'b0, 1'b0, 1'b0);

        for (int h = 0; h < 3; h++)
            for (int l = 0; l < 2; l++)
                for (int ld = 0; ld < 3; ld++)
                    for (int b = 0; b < 3; b++) begin
                        hv  = (h == 0) ? 0 : ((h == 1) ? 1 : 5);
                        lv  = (l == 0) ? 0 : 3;
                        liv = (ld == 0) ? 0 : ((ld == 1) ? 1 : 4);
                        bfv = (b == 0) ? 0 : ((b == 1) ? 2 : 5);
                        idx = ((h * 2 + l) * 3 + ld) * 3 + b;
                        hd = hv + 7;
                        ldur = lv + 2;
                        rov = (idx % 3 == 0) ? 0 : ((idx % 3 == 1) ? hd - 1 : hd);
                        xov = ((idx / 3) % 3 == 0) ? 0 :
                              (((idx / 3) % 3 == 1) ? ldur - 1 : ldur + 3);
                        run_xfer(16'(hv), 16'(lv), 16'(rov), 16'(xov), 16'(liv), 16'(bfv),
                                 1 + idx % 3, idx % 4 == 1, idx % 5 == 2, 1'b0, idx % 7 == 3);
                    end

        // R5: upper count bits ignored, largest low count
        run_xfer(16'hFC05, 16'hFFFF, 16'd11, 16'd1024, 16'd3, 16'd2, 2,
                 1'b0, 1'b0, 1'b0, 1'b0);
        chk(last_hi_len == 12, "R5", "high length with upper bits set", last_hi_len, 12);
        chk(last_lo_len == 1025, "R5", "low length with upper bits set", last_lo_len, 1025);

        // R11 / R10: words changed and start held during a transfer
        run_xfer(16'd4, 16'd2, 16'd3, 16'd1, 16'd2, 16'd3, 3,
                 1'b1, 1'b0, 1'b1, 1'b0);
        chk(last_hi_len == 11, "R11", "high length after word change", last_hi_len, 11);
        chk(last_lo_len == 4, "R11", "low length after word change", last_lo_len, 4);

        repeat (5) @(negedge clk);
        chk(phase_o == 3'd0, "R12", "idle code", int'(phase_o), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule